// File: doc/BRIEF.md
# Virtual-Machine Integer ALU

This block is the integer execution stage for a register-based 64-bit virtual machine. It receives an 8-bit opcode byte, the current value of the destination register, the value of the source register and a signed 32-bit immediate. One clock later it presents the value to be written back, a write strobe, and a flag for opcodes it does not execute.

The opcode byte has three fields. The high nibble selects the operation, bit 3 selects register or immediate as the second operand, and the low three bits select the operand width class. Narrow-class operations work on the low 32 bits and zero the upper half of the result. Division and remainder are unsigned and never trap. A zero divisor gives a defined result in both cases.

Top module: `vm_alu`

## Requirements
- R1: Opcode byte layout: bits 7:4 are the operation, bit 3 = 1 takes `src_val` as the second operand and bit 3 = 0 takes the immediate, and bits 2:0 are the class: 3'b111 is the 64-bit class and 3'b100 is the 32-bit (narrow) class.
- R2: The immediate is sign-extended to 64 bits before use. In the narrow class, both operands are cut to their low 32 bits and bits 63:32 of the result are 0.
- R3: Operation 0x0 adds, 0x1 subtracts (dst minus operand) and 0x2 multiplies. Each keeps the low bits, so it wraps modulo 2^64, or modulo 2^32 in the narrow class.
- R4: Operation 0x4 is OR, 0x5 is AND, 0xa is XOR and 0xb copies the second operand.
- R5: Operation 0x6 shifts left, 0x7 shifts right logically and 0xc shifts right arithmetically. The arithmetic shift in the narrow class takes its sign from bit 31. The shift amount is the second operand masked to 6 bits, or to 5 bits in the narrow class.
- R6: Operation 0x8 gives the two's complement negation of dst and ignores the second operand.
- R7: Operation 0x3 gives the unsigned quotient dst / operand. A zero divisor gives 0. In the narrow class the divisor is zero when its low 32 bits are zero.
- R8: Operation 0x9 gives the unsigned remainder. A zero divisor returns dst, cut to 32 bits in the narrow class.
- R9: These opcodes give `illegal` = 1, `wr_en` = 0 and `result` = 0: an operation code of 0xd to 0xf (0xd is byte swap, which this block does not execute), or a class other than 3'b100 or 3'b111.
- R10: Outputs appear one clock after `in_valid`. For a legal opcode, `wr_en` = 1. When `in_valid` is 0, the next cycle has `out_valid`, `wr_en` and `illegal` low, and `result` holds its last value.
- R11: While reset is applied, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 8 | Operation, source select and class |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Signed immediate |
| out_valid | output | 1 | Result cycle marker |
| result | output | 64 | Value to write to the destination |
| wr_en | output | 1 | Write-back strobe |
| illegal | output | 1 | Opcode not executed |

## Verification
The bench sweeps all 256 opcode bytes against eight operand sets. Each set is chosen to hit one trap:
- A source whose low half is zero while the full value is not. A design that tests the full divisor would divide instead of returning 0 or dst in the narrow class.
- Shift amounts above 31 and above 63. A missing mask would shift everything out.
- Negative immediates. Zero-extending them would give wrong unsigned quotients.
- A narrow arithmetic shift of a value with bit 31 set. Taking the sign from bit 63 would fill the result with the wrong bits.

Directed vectors check that an idle cycle leaves the result unchanged, and that byte-swap and unknown-class opcodes raise `illegal` instead of writing.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_LSH  = 4'h6,
    OP_RSH  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'ha,
    OP_MOV  = 4'hb,
    OP_ARSH = 4'hc,
    OP_SWAP = 4'hd,
    OP_RSVE = 4'he,
    OP_RSVF = 4'hf
  } alu_op_e;

  localparam logic [2:0] CLS_NARROW = 3'b100;
  localparam logic [2:0] CLS_WIDE   = 3'b111;

  typedef struct packed {
    alu_op_e op;
    logic    use_reg;
    logic    narrow;
    logic    legal;
  } alu_dec_t;

endpackage

// File: rtl/vm_alu_decode.sv
module vm_alu_decode
  import vm_alu_pkg::*;
(
  input  logic [7:0] opcode,
  output alu_dec_t   dec
);

  logic cls_ok;
  logic op_ok;

  always_comb begin
    cls_ok      = (opcode[2:0] == CLS_NARROW) || (opcode[2:0] == CLS_WIDE);
    op_ok       = (opcode[7:4] <= OP_ARSH);
    dec.op      = alu_op_e'(opcode[7:4]);
    dec.use_reg = opcode[3];
    dec.narrow  = (opcode[2:0] == CLS_NARROW);
    dec.legal   = cls_ok && op_ok;
  end

endmodule

// File: rtl/vm_alu_operands.sv
module vm_alu_operands #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              narrow,
  input  logic              use_reg,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);

  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] b_full;

  always_comb begin
    // sign extension happens before any unsigned interpretation
    imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    b_full  = use_reg ? src_val : imm_ext;
    if (narrow) begin
      op_a = {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
      op_b = {{HALF_W{1'b0}}, b_full[HALF_W-1:0]};
    end else begin
      op_a = dst_val;
      op_b = b_full;
    end
  end

endmodule

// File: rtl/vm_alu_shifter.sv
module vm_alu_shifter #(
  parameter int DATA_W = 64
) (
  input  logic                      narrow,
  input  logic [DATA_W-1:0]         op_a,
  input  logic [$clog2(DATA_W)-1:0] amt,
  output logic [DATA_W-1:0]         shl,
  output logic [DATA_W-1:0]         shr,
  output logic [DATA_W-1:0]         sar
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);

  logic [SH_W-1:0]   amt_m;
  logic [DATA_W-1:0] sar_src;

  always_comb begin
    // narrow class drops the top amount bit
    amt_m   = narrow ? {1'b0, amt[SH_W-2:0]} : amt;
    sar_src = narrow ? {{HALF_W{op_a[HALF_W-1]}}, op_a[HALF_W-1:0]} : op_a;
    shl     = op_a << amt_m;
    shr     = op_a >> amt_m;
    sar     = $signed(sar_src) >>> amt_m;
  end

endmodule

// File: rtl/vm_alu_divmod.sv
module vm_alu_divmod #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] quot,
  output logic [DATA_W-1:0] rem
);

  logic zero_div;

  always_comb begin
    zero_div = (op_b == '0);
    // zero divisor: quotient 0, remainder keeps the dividend
    quot = zero_div ? '0   : (op_a / op_b);
    rem  = zero_div ? op_a : (op_a % op_b);
  end

endmodule

// File: rtl/vm_alu.sv
module vm_alu
  import vm_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              illegal
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  alu_dec_t          dec;
  logic [DATA_W-1:0] op_a, op_b;
  logic [DATA_W-1:0] shl, shr, sar;
  logic [DATA_W-1:0] quot, rem;
  logic [DATA_W-1:0] raw_res, fin_res;

  vm_alu_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  vm_alu_operands #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .narrow  (dec.narrow),
    .use_reg (dec.use_reg),
    .dst_val (dst_val),
    .src_val (src_val),
    .imm     (imm),
    .op_a    (op_a),
    .op_b    (op_b)
  );

  vm_alu_shifter #(.DATA_W(DATA_W)) u_shf (
    .narrow (dec.narrow),
    .op_a   (op_a),
    .amt    (op_b[SH_W-1:0]),
    .shl    (shl),
    .shr    (shr),
    .sar    (sar)
  );

  vm_alu_divmod #(.DATA_W(DATA_W)) u_div (
    .op_a (op_a),
    .op_b (op_b),
    .quot (quot),
    .rem  (rem)
  );

  always_comb begin
    unique case (dec.op)
      OP_ADD:  raw_res = op_a + op_b;
      OP_SUB:  raw_res = op_a - op_b;
      OP_MUL:  raw_res = op_a * op_b;
      OP_DIV:  raw_res = quot;
      OP_OR:   raw_res = op_a | op_b;
      OP_AND:  raw_res = op_a & op_b;
      OP_LSH:  raw_res = shl;
      OP_RSH:  raw_res = shr;
      OP_NEG:  raw_res = '0 - op_a;
      OP_MOD:  raw_res = rem;
      OP_XOR:  raw_res = op_a ^ op_b;
      OP_MOV:  raw_res = op_b;
      OP_ARSH: raw_res = sar;
      default: raw_res = '0;
    endcase
    if (!dec.legal)      fin_res = '0;
    else if (dec.narrow) fin_res = {{HALF_W{1'b0}}, raw_res[HALF_W-1:0]};
    else                 fin_res = raw_res;
  end

  // next state
  logic              valid_d, wr_d, ill_d;
  logic [DATA_W-1:0] res_d;
  logic              res_en;

  always_comb begin
    valid_d = in_valid;
    wr_d    = in_valid &  dec.legal;
    ill_d   = in_valid & ~dec.legal;
    res_en  = in_valid;
    res_d   = fin_res;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      wr_en     <= wr_d;
      illegal   <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  result <= '0;
    else if (res_en) result <= res_d;
  end

endmodule

// File: rtl/vm_alu_chk.sv
module vm_alu_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] dst_val,
  input logic [DATA_W-1:0] src_val,
  input logic [IMM_W-1:0]  imm,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic              illegal
);

  localparam int HALF_W = DATA_W / 2;

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_en && !illegal));

  // R9
  excl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wr_en != illegal));

  // R9
  high_op_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[7:4] > 4'hc) |=> (illegal && !wr_en && result == '0));

  // R2
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[2:0] == 3'b100 && opcode[7:4] <= 4'hc)
      |=> (result[DATA_W-1:HALF_W] == '0));

  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h3f && src_val == '0) |=> (result == '0));

  // R8
  mod_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h9f && src_val == '0) |=> (result == $past(dst_val)));

  // R6
  neg_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'h87) |=> (result == ('0 - $past(dst_val))));

  // R4
  mov_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 8'hb7)
      |=> (result == {{(DATA_W-IMM_W){$past(imm[IMM_W-1])}}, $past(imm)}));

endmodule

bind vm_alu vm_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/vm_alu_test.sv
`timescale 1ns/1ps
module vm_alu_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  opcode;
  logic [63:0] dst_val, src_val;
  logic [31:0] imm;
  logic        out_valid, wr_en, illegal;
  logic [63:0] result;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vm_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .out_valid(out_valid), .result(result), .wr_en(wr_en), .illegal(illegal)
  );

  // reference model built from the requirement text
  function automatic logic [64:0] model(logic [7:0] opc, logic [63:0] d,
                                        logic [63:0] s, logic [31:0] im);
    logic [3:0]  op;
    logic [2:0]  cls;
    logic        w32, legal;
    logic [63:0] a, b, r, sx;
    logic [5:0]  sh;
    op    = opc[7:4];
    cls   = opc[2:0];
    w32   = (cls == 3'b100);
    legal = (w32 || cls == 3'b111) && (op <= 4'hc);           // R1 R9
    b     = opc[3] ? s : {{32{im[31]}}, im};                   // R2
    a     = d;
    if (w32) begin
      a = {32'h0, d[31:0]};
      b = {32'h0, b[31:0]};
    end
    sh = w32 ? {1'b0, b[4:0]} : b[5:0];                       // R5
    sx = w32 ? {{32{a[31]}}, a[31:0]} : a;
    case (op)
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h3: r = (b == 0) ? 64'h0 : a / b;                     // R7
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'h6: r = a << sh;
      4'h7: r = a >> sh;
      4'h8: r = 64'h0 - a;                                    // R6
      4'h9: r = (b == 0) ? a : a % b;                         // R8
      4'ha: r = a ^ b;
      4'hb: r = b;
      4'hc: r = $signed(sx) >>> sh;
      default: r = 64'h0;
    endcase
    if (w32)    r[63:32] = 32'h0;
    if (!legal) r = 64'h0;
    return {legal, r};
  endfunction

  function automatic string tag_of(logic [7:0] opc);
    logic [3:0] op;
    op = opc[7:4];
    if (!(opc[2:0] == 3'b100 || opc[2:0] == 3'b111) || op > 4'hc) return "R9";
    case (op)
      4'h0, 4'h1, 4'h2: return "R3";
      4'h3:             return "R7";
      4'h9:             return "R8";
      4'h8:             return "R6";
      4'h6, 4'h7, 4'hc: return "R5";
      default:          return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [66:0] got, logic [66:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic apply(string tag, logic [7:0] opc, logic [63:0] d,
                       logic [63:0] s, logic [31:0] im);
    logic [64:0] m;
    in_valid = 1'b1; opcode = opc; dst_val = d; src_val = s; imm = im;
    m = model(opc, d, s, im);
    @(negedge clk);
    check(tag, {out_valid, wr_en, illegal, result}, {1'b1, m[64], ~m[64], m[63:0]});
  endtask

  function automatic logic [159:0] pattern(int k);
    case (k)
      0: return {64'h0123456789abcdef, 64'h0000000000000005, 32'h00000003};
      1: return {64'hfedcba9876543210, 64'h0000000000000000, 32'h00000000};
      2: return {64'h8000000000000000, 64'hffffffffffffffff, 32'hffffffff};
      3: return {64'h00000000ffffffff, 64'h0000000100000000, 32'h80000000};
      4: return {64'hffffffff80000000, 64'd65,               32'h00000041};
      5: return {64'h123456789abcdef0, 64'h000000000000003f, 32'h00000021};
      6: return {64'h7fffffffffffffff, 64'h00000000fffffffe, 32'h7ffffffe};
      default: return {64'hdeadbeefcafef00d, 64'h1234567800000007, 32'hfffffff9};
    endcase
  endfunction

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; opcode = 8'h0;
    dst_val = '0; src_val = '0; imm = '0;
    repeat (3) @(negedge clk);
    // R11 outputs cleared during reset
    check("R11", {out_valid, wr_en, illegal, result}, 67'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 register versus immediate source
    apply("R1", 8'h0f, 64'd100, 64'd7, 32'd50);
    apply("R1", 8'h07, 64'd100, 64'd7, 32'd50);
    // R2 narrow class with negative immediate
    apply("R2", 8'h04, 64'hffffffff00000001, 64'h0, 32'hfffffffe);
    // R7 / R8 directed divisor corner values
    apply("R7", 8'h3f, 64'd5, 64'h0, 32'h0);
    apply("R7", 8'h37, 64'hffffffffffffffff, 64'h0, 32'hffffffff);
    apply("R8", 8'h9f, 64'h1234, 64'h0, 32'h0);
    apply("R8", 8'h94, 64'haaaabbbb00000007, 64'h0, 32'h0);
    // R9 byte swap and unknown class
    apply("R9", 8'hd7, 64'h1122334455667788, 64'h0, 32'd16);
    apply("R9", 8'h05, 64'h1, 64'h2, 32'h3);

    // R10 idle cycle keeps result, flags low
    apply("R10", 8'h0f, 64'd9, 64'd1, 32'h0);
    held = result;
    in_valid = 1'b0; opcode = 8'h8f; dst_val = 64'h55; src_val = 64'h0; imm = 32'h0;
    @(negedge clk);
    check("R10", {out_valid, wr_en, illegal, result}, {3'b000, held});

    // full opcode sweep over every operand pattern
    for (int k = 0; k < 8; k++) begin
      for (int o = 0; o < 256; o++) begin
        logic [159:0] p;
        p = pattern(k);
        apply(tag_of(8'(o)), 8'(o), p[159:96], p[95:32], p[31:0]);
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule